// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

A peripheral with several independent down-counting channels behind a simple single-cycle register bus. Each channel has three registers: control, interval and a read-only current count. The control word turns the channel on and requests an interval load. It also picks the tick source, sets a power-of-two prescale and chooses between periodic and one-shot operation.

A channel expires when a tick finds its count at one or zero. On expiry it sets a sticky per-channel pending bit. A periodic channel then reloads its interval. A one-shot channel parks at zero and clears its own enable. An interrupt-enable register gates the pending bits onto a single shared interrupt line.

Software enable and disable pass through a two-tick synchronisation stage in the counting-clock domain. Software must therefore allow two counting ticks after a disable before it reprograms a channel.

Top module: `mmio_down_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Register map, with byte addresses:
  - interrupt enable at 0x00, one bit per channel;
  - pending status at 0x04;
  - channel n control at 0x10*n+0x10, interval at 0x10*n+0x14 and count at 0x10*n+0x18.
  
  Any other address reads zero. Read data appears on `rdata_o` one clock after the read request and holds until the next read.
- R3: Control fields:
  - bit 0 is enable and bit 1 is reload request;
  - bits 3:2 pick the tick source: 0 is every clock, 1 is the `osc_tick_i` strobe, and 2 or 3 gives no ticks at all;
  - bits 6:4 are the prescale and bit 7 set means one-shot;
  - bits 31:8 read as zero.
- R4: The channel counts one prescaled tick per 2^prescale source ticks. The prescale phase restarts whenever the channel is not running.
- R5: On each prescaled tick the channel acts as follows:
  - a pending reload loads the interval and clears bit 1;
  - otherwise a count of 1 or 0 is an expiry, which sets the channel's pending bit and, in periodic mode, reloads the interval;
  - otherwise the count decrements by one.
- R6: A one-shot expiry sets the count to zero, clears the enable bit and stops the channel at once.
- R7: A software change of the enable bit takes effect after two source ticks, and the channel keeps counting until then.
- R8: A pending bit stays set until software writes 1 to that bit of the status register.
- R9: Writes to the count register are ignored. An interval write does not alter the count until the next load.
- R10: `irq_o` is high exactly when some channel has both its pending bit and its interrupt-enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | Oscillator tick strobe, synchronous to clk_i |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| irq_o | output | 1 | Shared interrupt line |

## Verification
A write lands at the clock edge that samples the request. Read data for a request is due at the following edge. A counter changes at the edge where its prescaled tick is high. A pending bit sets at that same expiry edge, so `irq_o` rises in the cycle that follows.

The bench drives inputs on the falling edge and advances a behavioural model at each rising edge. It compares `rdata_o` and `irq_o` against that model on every falling edge, so every result is sampled half a cycle after it is due. The directed checks read registers only after the bus task returns, which is past the edge that delivers the data.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned CTRL_W    = 8;
  localparam int unsigned PSC_W     = 3;
  localparam int unsigned OFF_IEN   = 'h00;
  localparam int unsigned OFF_STAT  = 'h04;
  localparam int unsigned CH_BASE   = 'h10;
  localparam int unsigned CH_STRIDE = 'h10;
  localparam int unsigned OFF_CTRL  = 'h0;
  localparam int unsigned OFF_INTV  = 'h4;
  localparam int unsigned OFF_CNT   = 'h8;

  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_OSC  = 2'd1,
    SRC_NONE = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;

  // packed MSB first: one-shot at bit 7 down to enable at bit 0
  typedef struct packed {
    logic             one_shot;
    logic [PSC_W-1:0] psc;
    logic [1:0]       src;
    logic             reload;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen import tmr_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic [1:0]       src_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             en_i,
  input  logic             kill_i,
  output logic             src_tick_o,
  output logic             run_o,
  output logic             tick_o
);
  localparam int unsigned PRE_W = (1 << PSC_W) - 1;

  logic [1:0]       sync_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    unique case (src_e'(src_i))
      SRC_SYS: src_tick_o = 1'b1;
      SRC_OSC: src_tick_o = osc_tick_i;
      default: src_tick_o = 1'b0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < int'(PRE_W); i++) mask[i] = (i < int'(psc_i));
  end

  assign run_o  = sync_q[1];
  assign tick_o = src_tick_o & run_o & ((pre_q & mask) == mask);

  // enable crosses into the counting domain over two source ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      pre_q  <= '0;
    end else if (kill_i) begin
      sync_q <= '0;
      pre_q  <= '0;
    end else if (src_tick_o) begin
      sync_q <= {sync_q[0], en_i};
      pre_q  <= run_o ? pre_q + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic             ctrl_we_i,
  input  logic             intv_we_i,
  input  logic [DW-1:0]    wdata_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] intv_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             tick_o,
  output logic             run_o,
  output logic             src_tick_o,
  output logic             kill_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] intv_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  tmr_tick_gen u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_tick_i (osc_tick_i),
    .src_i      (ctrl_q.src),
    .psc_i      (ctrl_q.psc),
    .en_i       (ctrl_q.en),
    .kill_i     (kill_o),
    .src_tick_o (src_tick_o),
    .run_o      (run_o),
    .tick_o     (tick_o)
  );

  assign at_end   = (cnt_q <= CNT_W'(1));
  assign expire_o = tick_o & ~ctrl_q.reload & at_end;
  assign kill_o   = expire_o & ctrl_q.one_shot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end else begin
      if (tick_o && ctrl_q.reload) ctrl_q.reload <= 1'b0;
      if (kill_o)                  ctrl_q.en     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        intv_q <= '0;
    else if (intv_we_i) intv_q <= wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      if (ctrl_q.reload)  cnt_q <= intv_q;
      else if (at_end)    cnt_q <= ctrl_q.one_shot ? '0 : intv_q;
      else                cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;
  assign intv_o = intv_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/mmio_down_timer.sv
module mmio_down_timer import tmr_pkg::*; #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned AW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          osc_tick_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic                    wr, rd, stat_we;
  logic [NUM_CH-1:0]       ctrl_we, intv_we;
  logic [NUM_CH-1:0]       expire_vec, tick_vec, run_vec, kill_vec, src_tick_vec, en_vec;
  logic [NUM_CH-1:0]       ien_q, pend_q, stat_clr;
  ctrl_t                   ctrl_arr [NUM_CH];
  logic [CNT_W-1:0]        intv_arr [NUM_CH];
  logic [CNT_W-1:0]        cnt_arr  [NUM_CH];
  logic [NUM_CH*CNT_W-1:0] cnt_flat;
  logic [DW-1:0]           rd_val, rdata_q;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign stat_we = wr && (addr_i == AW'(OFF_STAT));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned BASE = CH_BASE + CH_STRIDE * c;
    assign ctrl_we[c] = wr && (addr_i == AW'(BASE + OFF_CTRL));
    assign intv_we[c] = wr && (addr_i == AW'(BASE + OFF_INTV));

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .osc_tick_i (osc_tick_i),
      .ctrl_we_i  (ctrl_we[c]),
      .intv_we_i  (intv_we[c]),
      .wdata_i    (wdata_i),
      .ctrl_o     (ctrl_arr[c]),
      .intv_o     (intv_arr[c]),
      .cnt_o      (cnt_arr[c]),
      .expire_o   (expire_vec[c]),
      .tick_o     (tick_vec[c]),
      .run_o      (run_vec[c]),
      .src_tick_o (src_tick_vec[c]),
      .kill_o     (kill_vec[c])
    );

    assign en_vec[c]                    = ctrl_arr[c].en;
    assign cnt_flat[c*CNT_W +: CNT_W]   = cnt_arr[c];
  end

  assign stat_clr = stat_we ? wdata_i[NUM_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      if (wr && (addr_i == AW'(OFF_IEN))) ien_q <= wdata_i[NUM_CH-1:0];
      pend_q <= (pend_q & ~stat_clr) | expire_vec;
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == AW'(OFF_IEN))  rd_val[NUM_CH-1:0] = ien_q;
    if (addr_i == AW'(OFF_STAT)) rd_val[NUM_CH-1:0] = pend_q;
    for (int c = 0; c < int'(NUM_CH); c++) begin
      if (addr_i == AW'(CH_BASE + CH_STRIDE * c + OFF_CTRL)) rd_val[CTRL_W-1:0] = ctrl_arr[c];
      if (addr_i == AW'(CH_BASE + CH_STRIDE * c + OFF_INTV)) rd_val[CNT_W-1:0]  = intv_arr[c];
      if (addr_i == AW'(CH_BASE + CH_STRIDE * c + OFF_CNT))  rd_val[CNT_W-1:0]  = cnt_arr[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(pend_q & ien_q);
endmodule

// File: rtl/mmio_down_timer_chk.sv
module mmio_down_timer_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned AW     = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    stat_we,
  input logic [NUM_CH-1:0]       wmask,
  input logic [NUM_CH-1:0]       pend_q,
  input logic [NUM_CH-1:0]       ien_q,
  input logic                    irq_o,
  input logic [NUM_CH-1:0]       tick_vec,
  input logic [NUM_CH-1:0]       expire_vec,
  input logic [NUM_CH-1:0]       run_vec,
  input logic [NUM_CH-1:0]       kill_vec,
  input logic [NUM_CH-1:0]       src_tick_vec,
  input logic [NUM_CH-1:0]       en_vec,
  input logic [NUM_CH-1:0]       ctrl_we,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat
);
  logic [NUM_CH-1:0] keep;
  assign keep = pend_q & ~(stat_we ? wmask : '0);

  p_pend_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|keep) |=> ((pend_q & $past(keep)) == $past(keep)));

  p_irq_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend_q != '0) && (ien_q != '0)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_cnt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_vec[c] |=> $stable(cnt_flat[c*CNT_W +: CNT_W]));

    p_pend_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_vec[c] |=> pend_q[c]);

    p_oneshot_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kill_vec[c] && !ctrl_we[c]) |=> (!en_vec[c] && !run_vec[c]));

    p_run_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_vec[c] && !src_tick_vec[c] && !kill_vec[c]) |=> run_vec[c]);
  end
endmodule

bind mmio_down_timer mmio_down_timer_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .AW     (AW)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stat_we      (stat_we),
  .wmask        (wdata_i[NUM_CH-1:0]),
  .pend_q       (pend_q),
  .ien_q        (ien_q),
  .irq_o        (irq_o),
  .tick_vec     (tick_vec),
  .expire_vec   (expire_vec),
  .run_vec      (run_vec),
  .kill_vec     (kill_vec),
  .src_tick_vec (src_tick_vec),
  .en_vec       (en_vec),
  .ctrl_we      (ctrl_we),
  .cnt_flat     (cnt_flat)
);

// File: tb/mmio_down_timer_tb_top.sv
module mmio_down_timer_tb_top;
  localparam int NUM_CH = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        osc_tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int    compares = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    osc_on = 1'b0;
  int    osc_cnt = 0;

  // behavioural reference state
  logic [7:0]  m_ctrl [NUM_CH];
  logic [31:0] m_intv [NUM_CH];
  logic [31:0] m_cnt  [NUM_CH];
  bit   [1:0]  m_sync [NUM_CH];
  int          m_pre  [NUM_CH];
  logic [NUM_CH-1:0] m_ien, m_pend;
  logic [31:0] m_rdata;
  bit          m_irq;

  mmio_down_timer #(.NUM_CH(NUM_CH), .CNT_W(32), .AW(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_tick_i(osc_tick_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    osc_cnt++;
    osc_tick_i = osc_on && (osc_cnt % 4 == 0);
  end

  function automatic logic [31:0] m_read(int a);
    if (a == 'h00) return 32'(m_ien);
    if (a == 'h04) return 32'(m_pend);
    for (int c = 0; c < NUM_CH; c++) begin
      if (a == 'h10 + 'h10 * c) return 32'(m_ctrl[c]);
      if (a == 'h14 + 'h10 * c) return m_intv[c];
      if (a == 'h18 + 'h10 * c) return m_cnt[c];
    end
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NUM_CH; c++) begin
      m_ctrl[c] = '0; m_intv[c] = '0; m_cnt[c] = '0; m_sync[c] = '0; m_pre[c] = 0;
    end
    m_ien = '0; m_pend = '0; m_rdata = '0; m_irq = 1'b0;
  endtask

  task automatic model_step();
    logic [31:0] rv;
    logic [NUM_CH-1:0] ex_v;
    bit wr;
    rv   = m_read(int'(addr_i));
    ex_v = '0;
    wr   = req_i && we_i;
    for (int c = 0; c < NUM_CH; c++) begin
      int  base, psc, mask, src;
      bit  s, run, tick, rld, os, ex;
      base = 'h10 + 'h10 * c;
      src  = int'(m_ctrl[c][3:2]);
      psc  = int'(m_ctrl[c][6:4]);
      mask = (1 << psc) - 1;
      s    = (src == 0) ? 1'b1 : (src == 1) ? osc_tick_i : 1'b0;
      run  = m_sync[c][1];
      tick = s && run && ((m_pre[c] & mask) == mask);
      rld  = m_ctrl[c][1];
      os   = m_ctrl[c][7];
      ex   = tick && !rld && (m_cnt[c] <= 1);
      ex_v[c] = ex;
      if (tick) begin
        if (rld) m_cnt[c] = m_intv[c];
        else if (m_cnt[c] <= 1) m_cnt[c] = os ? 32'h0 : m_intv[c];
        else m_cnt[c] = m_cnt[c] - 1;
      end
      if (ex && os) begin
        m_sync[c] = '0; m_pre[c] = 0;
      end else if (s) begin
        m_pre[c]  = run ? (m_pre[c] + 1) % 128 : 0;
        m_sync[c] = {m_sync[c][0], m_ctrl[c][0]};
      end
      if (wr && int'(addr_i) == base) m_ctrl[c] = wdata_i[7:0];
      else begin
        if (tick && rld) m_ctrl[c][1] = 1'b0;
        if (ex && os)    m_ctrl[c][0] = 1'b0;
      end
      if (wr && int'(addr_i) == base + 4) m_intv[c] = wdata_i;
    end
    if (wr && addr_i == 8'h04) m_pend = m_pend & ~wdata_i[NUM_CH-1:0];
    m_pend = m_pend | ex_v;
    if (wr && addr_i == 8'h00) m_ien = wdata_i[NUM_CH-1:0];
    if (req_i && !we_i) m_rdata = rv;
    m_irq = |(m_pend & m_ien);
  endtask

  initial model_reset();
  always @(posedge clk_i) begin
    if (!rst_ni) model_reset();
    else model_step();
  end

  // cycle compare against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      compares++;
      if (rdata_o !== m_rdata || irq_o !== m_irq) begin
        fails++;
        $display("FAIL %s: rdata act %h exp %h, irq act %b exp %b",
                 cur_req, rdata_o, m_rdata, irq_o, m_irq);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compares++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic poll(logic [7:0] a, int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) bus_rd(a, d);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compares, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: act running exp finished");
    finish_run();
  end

  initial begin
    logic [31:0] d, a0, b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;

    cur_req = "R1";
    chk("R1 irq", 32'(irq_o), 32'h0);
    bus_rd(8'h00, d); chk("R1 ien", d, 32'h0);
    bus_rd(8'h04, d); chk("R1 stat", d, 32'h0);
    bus_rd(8'h10, d); chk("R1 ctrl0", d, 32'h0);
    bus_rd(8'h28, d); chk("R1 cnt1", d, 32'h0);

    cur_req = "R3";
    bus_wr(8'h10, 32'hFFFF_FF70);
    bus_rd(8'h10, d); chk("R3 ctrl upper bits", d, 32'h70);
    bus_wr(8'h10, 32'h0);
    cur_req = "R2";
    bus_wr(8'h30, 32'hFF);
    bus_rd(8'h30, d); chk("R2 unmapped", d, 32'h0);
    bus_wr(8'h24, 32'hCAFE_F00D);
    bus_rd(8'h24, d); chk("R2 intv1", d, 32'hCAFE_F00D);

    cur_req = "R5";
    bus_wr(8'h00, 32'h3);
    bus_wr(8'h14, 32'd3);
    bus_wr(8'h10, 32'h03);
    poll(8'h18, 12);
    bus_rd(8'h04, d); chk("R5 pend0", d & 32'h1, 32'h1);
    chk("R10 irq high", 32'(irq_o), 32'h1);
    bus_rd(8'h10, d); chk("R5 reload self-clear", d, 32'h01);

    cur_req = "R7";
    bus_wr(8'h10, 32'h00);
    poll(8'h18, 6);
    bus_rd(8'h18, a0);
    repeat (4) @(negedge clk_i);
    bus_rd(8'h18, b0); chk("R7 stopped", b0, a0);

    cur_req = "R8";
    bus_wr(8'h04, 32'h1);
    bus_rd(8'h04, d); chk("R8 w1c", d, 32'h0);
    chk("R8 irq low", 32'(irq_o), 32'h0);

    cur_req = "R9";
    bus_wr(8'h18, 32'h1234_5678);
    bus_rd(8'h18, d); chk("R9 cnt write ignored", d, a0);
    bus_wr(8'h14, 32'd9);
    bus_rd(8'h18, d); chk("R9 intv no effect", d, a0);
    bus_rd(8'h14, d); chk("R9 intv read", d, 32'd9);

    cur_req = "R4";
    bus_wr(8'h24, 32'd1);
    bus_wr(8'h20, 32'h73);
    repeat (100) @(negedge clk_i);
    bus_rd(8'h04, d); chk("R4 no tick before 128", d & 32'h2, 32'h0);
    bus_rd(8'h28, d); chk("R4 cnt1 not loaded", d, 32'h0);
    bus_wr(8'h20, 32'h0);
    repeat (5) @(negedge clk_i);
    bus_wr(8'h10, 32'h23);
    poll(8'h18, 30);
    bus_wr(8'h10, 32'h0);
    poll(8'h18, 5);

    cur_req = "R6";
    bus_wr(8'h24, 32'd5);
    bus_wr(8'h20, 32'h83);
    poll(8'h28, 15);
    bus_rd(8'h20, d); chk("R6 en cleared", d, 32'h80);
    bus_rd(8'h28, d); chk("R6 cnt zero", d, 32'h0);
    bus_rd(8'h04, d); chk("R6 pend1", d & 32'h2, 32'h2);

    cur_req = "R10";
    bus_wr(8'h00, 32'h0);
    chk("R10 masked", 32'(irq_o), 32'h0);
    bus_wr(8'h00, 32'h2);
    chk("R10 unmasked", 32'(irq_o), 32'h1);

    cur_req = "R3";
    osc_on = 1'b1;
    bus_wr(8'h14, 32'd1000);
    bus_wr(8'h10, 32'h07);
    poll(8'h18, 20);
    bus_wr(8'h10, 32'h09);
    bus_rd(8'h18, a0);
    repeat (5) @(negedge clk_i);
    bus_rd(8'h18, b0); chk("R3 no-tick source", b0, a0);
    chk("R3 osc counted", 32'(a0 < 32'd1000 && a0 != 0), 32'h1);

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule